// File: doc/BRIEF.md
# Four-Lane Word/Byte FIFO

This block buffers data in both directions between a 32-bit register bus and a serial shift engine. Each direction is built from four byte-wide storage lanes of equal depth (16 entries by default). A word access touches all four lanes in one cycle and moves four bytes. A byte access touches lane 0 only. The word port therefore sees four times the depth that the byte port sees. The serial engine always sees a plain byte stream.

On the transmit side the bus writes and the serial engine drains bytes. Bytes written as a word leave lowest byte first. Bytes written singly leave in write order between words. On the receive side the serial engine pushes bytes. A mode input selects where they go. In word mode they are spread round-robin over the four lanes, so the bus can collect them as words. In byte mode they all go to lane 0, so the bus reads them one at a time.

Level conditions for both directions, plus a pulse for refused accesses, feed a sticky status register. Writing a one to a bit clears it, and the bit sets again at once if its condition still holds. An enable mask combines the status bits into one interrupt line.

Top module: `quad_lane_fifo`

## Requirements
- R1: While reset is high, `int_status`, `irq`, `tx_ser_valid` and `rx_rdata` are all zero. One clock after reset is released, `int_status` reads 0x04, which is the transmit-empty bit alone.
- R2: The serial side drains the bytes of each transmit word in the order bits 7:0, 15:8, 23:16, 31:24. A transmit byte write queues bits 7:0 only, and bytes leave in the order they were written, with word writes and byte writes interleaved.
- R3: The transmit word port accepts 4*LANE_DEPTH bytes (16 words) and the byte port accepts LANE_DEPTH bytes. A write beyond that is refused as a whole, queues nothing, and sets status bit 7.
- R4: Transmit flags. Bit 0 (full) means some lane is full when `word_mode` is 1, or lane 0 is full when `word_mode` is 0. Bit 1 (half) means the queued byte count is at least 2*LANE_DEPTH in word mode, or at least LANE_DEPTH/2 in byte mode. Bit 2 (empty) means no byte is queued.
- R5: In receive word mode, pushed bytes fill lanes 0,1,2,3 in turn, and a word read returns the four lane heads with lane 0 in bits 7:0. In receive byte mode, bytes go to lane 0 only, and a byte read returns the head of lane 0 zero-extended.
- R6: Status bit 5 (word available) is set when all four receive lanes hold data. Status bit 6 (byte available) is set when receive lane 0 holds data.
- R7: These accesses are refused and set status bit 7: a receive word read without a word available, a byte read with lane 0 empty, and a serial push into a full target lane. A refused access removes no data, and `rx_rdata` changes only on an accepted read.
- R8: Raising the word strobe and the byte strobe in the same cycle, on either the transmit write side or the receive read side, is refused and sets status bit 7.
- R9: Status bits are sticky. A one written on `int_clr` clears a bit only if its condition is absent in that cycle, so a bit whose condition still holds stays set.
- R10: `irq` is high exactly when some status bit is set whose enable bit was set on the previous clock.
- R11: Receive flags. Bit 3 (full) means some lane is full in word mode, or lane 0 is full in byte mode. Bit 4 (half) uses the same byte-count thresholds as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 selects the word-port depth for the flags and round-robin receive fill |
| tx_wr_word | input | 1 | Transmit word write strobe |
| tx_wr_byte | input | 1 | Transmit byte write strobe (uses bits 7:0) |
| tx_wdata | input | BUS_W | Transmit write data |
| tx_ser_valid | output | 1 | A transmit byte is offered to the serial engine |
| tx_ser_data | output | 8 | Offered transmit byte |
| tx_ser_pop | input | 1 | Serial engine takes the offered byte |
| rx_ser_push | input | 1 | Serial engine delivers a received byte |
| rx_ser_data | input | 8 | Received byte |
| rx_rd_word | input | 1 | Receive word read strobe |
| rx_rd_byte | input | 1 | Receive byte read strobe |
| rx_rdata | output | BUS_W | Registered receive read data |
| int_clr | input | 8 | Write-one-to-clear mask for the status bits |
| int_en | input | 8 | Interrupt enable mask |
| int_status | output | 8 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
A lane counter that is off by one shows up on the flags one cycle after the access that caused it. It also shows when the bench sweeps every fill level, because a refused or accepted access at the boundary comes out wrong. A drain-phase register that skips or repeats a lane corrupts the very next serial byte, and the bench compares every byte of the stream. A wrong receive fill pointer puts the bytes of the next word read out of order, so the error is visible as soon as that word is read back. Loss of stickiness, or clearing while the condition still holds, is visible in the cycle after the clear.

// File: rtl/qlf_pkg.sv
`timescale 1ns/1ps
package qlf_pkg;
  localparam int ST_W        = 8;
  localparam int ST_TX_FULL  = 0;
  localparam int ST_TX_HALF  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_RX_FULL  = 3;
  localparam int ST_RX_HALF  = 4;
  localparam int ST_RX_WORD  = 5;
  localparam int ST_RX_BYTE  = 6;
  localparam int ST_ILLEGAL  = 7;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } tx_flags_t;

  typedef struct packed {
    logic full;
    logic half;
    logic word_avail;
    logic byte_avail;
  } rx_flags_t;
endpackage

// File: rtl/qlf_lane.sv
`timescale 1ns/1ps
// One byte lane: simple circular buffer, storage without reset.
module qlf_lane #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign count = cnt_q;
endmodule

// File: rtl/qlf_tx_path.sv
`timescale 1ns/1ps
// Transmit direction: bus writes words or bytes, serial side drains bytes.
module qlf_tx_path import qlf_pkg::*; #(
  parameter  int BUS_W      = 32,
  parameter  int LANE_DEPTH = 16,
  localparam int LANES      = BUS_W / 8,
  localparam int CW         = $clog2(LANE_DEPTH + 1),
  localparam int TW         = $clog2(LANES * LANE_DEPTH + 1),
  localparam int PW         = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             wr_word,
  input  logic             wr_byte,
  input  logic [BUS_W-1:0] wdata,
  output logic             ser_valid,
  output logic [7:0]       ser_data,
  input  logic             ser_pop,
  output tx_flags_t        flags,
  output logic             illegal
);
  localparam logic [TW-1:0] THR_WORD = TW'(LANES * LANE_DEPTH / 2);
  localparam logic [TW-1:0] THR_BYTE = TW'(LANE_DEPTH / 2);

  logic [LANES-1:0] push, pop, lfull, lempty;
  logic [7:0]       head [LANES];
  logic [CW-1:0]    cnt  [LANES];
  logic             tag_head;
  logic [PW-1:0]    ph;
  logic             any_full, word_ok, byte_ok;
  logic [TW-1:0]    total;

  assign any_full = |lfull;
  assign word_ok  = wr_word & ~wr_byte & ~any_full;
  assign byte_ok  = wr_byte & ~wr_word & ~lfull[0];
  assign illegal  = (wr_word & wr_byte) | (wr_word & ~wr_byte & any_full) |
                    (wr_byte & ~wr_word & lfull[0]);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_tagged
      logic [8:0] d0;
      qlf_lane #(.WIDTH(9), .DEPTH(LANE_DEPTH)) u_lane (
        .clk(clk), .rst(rst), .push(push[0]), .din({word_ok, wdata[7:0]}),
        .pop(pop[0]), .dout(d0), .count(cnt[0]));
      assign head[0]  = d0[7:0];
      assign tag_head = d0[8];
      assign push[0]  = word_ok | byte_ok;
    end else begin : g_plain
      qlf_lane #(.WIDTH(8), .DEPTH(LANE_DEPTH)) u_lane (
        .clk(clk), .rst(rst), .push(push[i]), .din(wdata[8*i +: 8]),
        .pop(pop[i]), .dout(head[i]), .count(cnt[i]));
      assign push[i] = word_ok;
    end
    assign lfull[i]  = (cnt[i] == CW'(LANE_DEPTH));
    assign lempty[i] = (cnt[i] == '0);
    assign pop[i]    = ser_pop & ser_valid & (ph == PW'(i));
  end

  assign ser_valid = ~lempty[ph];
  assign ser_data  = head[ph];

  // Drain phase: lane 0 first; a word-tagged byte continues into lanes 1..3.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (ser_pop && ser_valid) begin
      if (ph == '0)                  ph <= tag_head ? PW'(1) : '0;
      else if (ph == PW'(LANES - 1)) ph <= '0;
      else                           ph <= ph + PW'(1);
    end
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total += TW'(cnt[i]);
  end

  assign flags.full  = word_mode ? any_full : lfull[0];
  assign flags.half  = total >= (word_mode ? THR_WORD : THR_BYTE);
  assign flags.empty = (total == '0);
endmodule

// File: rtl/qlf_rx_path.sv
`timescale 1ns/1ps
// Receive direction: serial side pushes bytes, bus reads words or bytes.
module qlf_rx_path import qlf_pkg::*; #(
  parameter  int BUS_W      = 32,
  parameter  int LANE_DEPTH = 16,
  localparam int LANES      = BUS_W / 8,
  localparam int CW         = $clog2(LANE_DEPTH + 1),
  localparam int TW         = $clog2(LANES * LANE_DEPTH + 1),
  localparam int PW         = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             ser_push,
  input  logic [7:0]       ser_data,
  input  logic             rd_word,
  input  logic             rd_byte,
  output logic [BUS_W-1:0] rdata,
  output rx_flags_t        flags,
  output logic             illegal
);
  localparam logic [TW-1:0] THR_WORD = TW'(LANES * LANE_DEPTH / 2);
  localparam logic [TW-1:0] THR_BYTE = TW'(LANE_DEPTH / 2);

  logic [LANES-1:0] push, pop, lfull, lempty;
  logic [7:0]       head [LANES];
  logic [CW-1:0]    cnt  [LANES];
  logic [PW-1:0]    fp, target;
  logic             push_ok, word_av, byte_av, rdw_ok, rdb_ok;
  logic [TW-1:0]    total;
  logic [BUS_W-1:0] word_bus, rdata_q;

  assign target  = word_mode ? fp : '0;
  assign push_ok = ser_push & ~lfull[target];
  assign word_av = ~|lempty;
  assign byte_av = ~lempty[0];
  assign rdw_ok  = rd_word & ~rd_byte & word_av;
  assign rdb_ok  = rd_byte & ~rd_word & byte_av;
  assign illegal = (ser_push & lfull[target]) | (rd_word & rd_byte) |
                   (rd_word & ~rd_byte & ~word_av) | (rd_byte & ~rd_word & ~byte_av);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    qlf_lane #(.WIDTH(8), .DEPTH(LANE_DEPTH)) u_lane (
      .clk(clk), .rst(rst), .push(push[i]), .din(ser_data),
      .pop(pop[i]), .dout(head[i]), .count(cnt[i]));
    assign push[i]   = push_ok & (target == PW'(i));
    assign pop[i]    = rdw_ok | ((i == 0) & rdb_ok);
    assign lfull[i]  = (cnt[i] == CW'(LANE_DEPTH));
    assign lempty[i] = (cnt[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)             fp <= '0;
    else if (!word_mode) fp <= '0;
    else if (push_ok)    fp <= fp + PW'(1);
  end

  always_comb begin
    word_bus = '0;
    for (int i = 0; i < LANES; i++) word_bus[8*i +: 8] = head[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rdw_ok) rdata_q <= word_bus;
    else if (rdb_ok) rdata_q <= {{(BUS_W-8){1'b0}}, head[0]};
  end
  assign rdata = rdata_q;

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total += TW'(cnt[i]);
  end

  assign flags.full       = word_mode ? ~&(~lfull) : lfull[0];
  assign flags.half       = total >= (word_mode ? THR_WORD : THR_BYTE);
  assign flags.word_avail = word_av;
  assign flags.byte_avail = byte_av;
endmodule

// File: rtl/qlf_status.sv
`timescale 1ns/1ps
// Sticky status with write-one-to-clear; a live condition wins over a clear.
module qlf_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] st_q, st_d;
  logic         irq_q;

  always_comb st_d = (st_q & ~clr) | cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= |(st_d & en);
    end
  end

  assign status = st_q;
  assign irq    = irq_q;
endmodule

// File: rtl/quad_lane_fifo.sv
`timescale 1ns/1ps
module quad_lane_fifo import qlf_pkg::*; #(
  parameter int BUS_W      = 32,
  parameter int LANE_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             tx_wr_word,
  input  logic             tx_wr_byte,
  input  logic [BUS_W-1:0] tx_wdata,
  output logic             tx_ser_valid,
  output logic [7:0]       tx_ser_data,
  input  logic             tx_ser_pop,
  input  logic             rx_ser_push,
  input  logic [7:0]       rx_ser_data,
  input  logic             rx_rd_word,
  input  logic             rx_rd_byte,
  output logic [BUS_W-1:0] rx_rdata,
  input  logic [ST_W-1:0]  int_clr,
  input  logic [ST_W-1:0]  int_en,
  output logic [ST_W-1:0]  int_status,
  output logic             irq
);
  tx_flags_t       txf;
  rx_flags_t       rxf;
  logic            tx_ill, rx_ill;
  logic            tx_empty_w, rx_word_w;
  logic [ST_W-1:0] cond;

  qlf_tx_path #(.BUS_W(BUS_W), .LANE_DEPTH(LANE_DEPTH)) u_tx (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .wr_word(tx_wr_word), .wr_byte(tx_wr_byte), .wdata(tx_wdata),
    .ser_valid(tx_ser_valid), .ser_data(tx_ser_data), .ser_pop(tx_ser_pop),
    .flags(txf), .illegal(tx_ill));

  qlf_rx_path #(.BUS_W(BUS_W), .LANE_DEPTH(LANE_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .ser_push(rx_ser_push), .ser_data(rx_ser_data),
    .rd_word(rx_rd_word), .rd_byte(rx_rd_byte), .rdata(rx_rdata),
    .flags(rxf), .illegal(rx_ill));

  assign tx_empty_w = txf.empty;
  assign rx_word_w  = rxf.word_avail;

  always_comb begin
    cond              = '0;
    cond[ST_TX_FULL]  = txf.full;
    cond[ST_TX_HALF]  = txf.half;
    cond[ST_TX_EMPTY] = txf.empty;
    cond[ST_RX_FULL]  = rxf.full;
    cond[ST_RX_HALF]  = rxf.half;
    cond[ST_RX_WORD]  = rxf.word_avail;
    cond[ST_RX_BYTE]  = rxf.byte_avail;
    cond[ST_ILLEGAL]  = tx_ill | rx_ill;
  end

  qlf_status #(.W(ST_W)) u_status (
    .clk(clk), .rst(rst), .cond(cond), .clr(int_clr), .en(int_en),
    .status(int_status), .irq(irq));
endmodule

// File: rtl/qlf_checker.sv
`timescale 1ns/1ps
module qlf_checker import qlf_pkg::*; #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_wr_word,
  input logic             tx_wr_byte,
  input logic             rx_rd_word,
  input logic             rx_rd_byte,
  input logic [BUS_W-1:0] rx_rdata,
  input logic [ST_W-1:0]  int_clr,
  input logic [ST_W-1:0]  int_en,
  input logic [ST_W-1:0]  int_status,
  input logic             irq,
  input logic             tx_ser_valid,
  input logic             tx_empty_w,
  input logic             rx_word_w
);
  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst) irq == |(int_status & $past(int_en))); // R10
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst) (int_status[ST_ILLEGAL] && !int_clr[ST_ILLEGAL]) |=> int_status[ST_ILLEGAL]); // R9
  AST_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (rst) (tx_wr_word && tx_wr_byte) |=> int_status[ST_ILLEGAL]); // R8
  AST_TX_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (rst) tx_ser_valid |-> !tx_empty_w); // R2
  AST_RX_WORD_REFUSED: assert property (@(posedge clk) disable iff (rst) (rx_rd_word && !rx_rd_byte && !rx_word_w) |=> int_status[ST_ILLEGAL]); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst) (!rx_rd_word && !rx_rd_byte) |=> $stable(rx_rdata)); // R7
endmodule

bind quad_lane_fifo qlf_checker #(.BUS_W(BUS_W)) i_qlf_checker (
  .clk(clk), .rst(rst), .tx_wr_word(tx_wr_word), .tx_wr_byte(tx_wr_byte),
  .rx_rd_word(rx_rd_word), .rx_rd_byte(rx_rd_byte), .rx_rdata(rx_rdata),
  .int_clr(int_clr), .int_en(int_en), .int_status(int_status), .irq(irq),
  .tx_ser_valid(tx_ser_valid), .tx_empty_w(tx_empty_w), .rx_word_w(rx_word_w));

// File: tb/test_quad_lane_fifo.sv
`timescale 1ns/1ps
module test_quad_lane_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0;
  logic        tx_wr_word = 1'b0, tx_wr_byte = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_ser_valid;
  logic [7:0]  tx_ser_data;
  logic        tx_ser_pop = 1'b0;
  logic        rx_ser_push = 1'b0;
  logic [7:0]  rx_ser_data = '0;
  logic        rx_rd_word = 1'b0, rx_rd_byte = 1'b0;
  logic [31:0] rx_rdata;
  logic [7:0]  int_clr = '0, int_en = '0;
  logic [7:0]  int_status;
  logic        irq;

  int nchecks = 0;
  int nfail   = 0;

  always #5 clk = ~clk;

  quad_lane_fifo #(.BUS_W(32), .LANE_DEPTH(16)) i_quad_lane_fifo (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .tx_wr_word(tx_wr_word), .tx_wr_byte(tx_wr_byte), .tx_wdata(tx_wdata),
    .tx_ser_valid(tx_ser_valid), .tx_ser_data(tx_ser_data), .tx_ser_pop(tx_ser_pop),
    .rx_ser_push(rx_ser_push), .rx_ser_data(rx_ser_data),
    .rx_rd_word(rx_rd_word), .rx_rd_byte(rx_rd_byte), .rx_rdata(rx_rdata),
    .int_clr(int_clr), .int_en(int_en), .int_status(int_status), .irq(irq));

  task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  // bit7 illegal, 6 rx byte, 5 rx word, 4 rx half, 3 rx full, 2 tx empty, 1 tx half, 0 tx full
  function automatic logic [7:0] mk(input logic txf, txh, txe, rxf, rxh, rxw, rxb, ill);
    return {ill, rxb, rxw, rxh, rxf, txe, txh, txf};
  endfunction

  task automatic snap(output logic [7:0] s);
    int_clr = 8'hFF;
    @(negedge clk);
    int_clr = 8'h00;
    s = int_status;
  endtask

  task automatic expect_ill(input string req);
    logic [7:0] s;
    ceq(req, {31'd0, int_status[7]}, 32'd1);
    snap(s);
  endtask

  task automatic tx_word(input logic [31:0] w);
    tx_wr_word = 1'b1; tx_wdata = w;
    @(negedge clk);
    tx_wr_word = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b);
    tx_wr_byte = 1'b1; tx_wdata = {24'hABCDEF, b};
    @(negedge clk);
    tx_wr_byte = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    ceq(req, {23'd0, tx_ser_valid, tx_ser_data}, {23'd0, 1'b1, exp});
    tx_ser_pop = 1'b1;
    @(negedge clk);
    tx_ser_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_ser_push = 1'b1; rx_ser_data = b;
    @(negedge clk);
    rx_ser_push = 1'b0;
  endtask

  task automatic rx_read(input logic word, input logic byt);
    rx_rd_word = word; rx_rd_byte = byt;
    @(negedge clk);
    rx_rd_word = 1'b0; rx_rd_byte = 1'b0;
  endtask

  function automatic logic [7:0] pa(input int m);
    return 8'(m) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pr(input int m);
    return 8'(m) ^ 8'h3C;
  endfunction

  initial begin
    #1_500_000;
    nchecks++; nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0]  s;
    logic [31:0] last;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    ceq("R1 status in reset", {24'd0, int_status}, 32'd0);
    ceq("R1 irq in reset", {31'd0, irq}, 32'd0);
    ceq("R1 tx valid in reset", {31'd0, tx_ser_valid}, 32'd0);
    ceq("R1 rdata in reset", rx_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    ceq("R1 status after reset", {24'd0, int_status}, 32'h04);

    // R3 R4 word port sweep
    word_mode = 1'b1;
    for (int k = 0; k <= 16; k++) begin
      snap(s);
      ceq("R4 tx flags word mode", {24'd0, s}, {24'd0, mk(k == 16, 4*k >= 32, k == 0, 0, 0, 0, 0, 0)});
      if (k < 16) tx_word({pa(4*k+3), pa(4*k+2), pa(4*k+1), pa(4*k)});
    end
    tx_word(32'hFFFF_FFFF);
    expect_ill("R3 word overflow refused");
    for (int m = 0; m < 64; m++) tx_take("R2 word drain order", pa(m));
    ceq("R3 refused word not queued", {31'd0, tx_ser_valid}, 32'd0);

    // R3 R4 byte port sweep
    word_mode = 1'b0;
    for (int k = 0; k <= 16; k++) begin
      snap(s);
      ceq("R4 tx flags byte mode", {24'd0, s}, {24'd0, mk(k == 16, k >= 8, k == 0, 0, 0, 0, 0, 0)});
      if (k < 16) tx_byte(8'(k*7 + 1));
    end
    tx_byte(8'hEE);
    expect_ill("R3 byte overflow refused");
    for (int k = 0; k < 16; k++) tx_take("R2 byte drain order", 8'(k*7 + 1));
    ceq("R3 refused byte not queued", {31'd0, tx_ser_valid}, 32'd0);

    // R2 mixed words and bytes
    word_mode = 1'b1;
    tx_word(32'h4433_2211);
    tx_byte(8'h99);
    tx_word(32'hDDCC_BBAA);
    tx_byte(8'h77);
    tx_take("R2 mixed", 8'h11); tx_take("R2 mixed", 8'h22);
    tx_take("R2 mixed", 8'h33); tx_take("R2 mixed", 8'h44);
    tx_take("R2 mixed", 8'h99); tx_take("R2 mixed", 8'hAA);
    tx_take("R2 mixed", 8'hBB); tx_take("R2 mixed", 8'hCC);
    tx_take("R2 mixed", 8'hDD); tx_take("R2 mixed", 8'h77);
    ceq("R2 mixed drained", {31'd0, tx_ser_valid}, 32'd0);

    // R8 double strobe on transmit
    snap(s);
    tx_wr_word = 1'b1; tx_wr_byte = 1'b1; tx_wdata = 32'h1234_5678;
    @(negedge clk);
    tx_wr_word = 1'b0; tx_wr_byte = 1'b0;
    ceq("R8 double tx write queues nothing", {31'd0, tx_ser_valid}, 32'd0);
    expect_ill("R8 double tx write flagged");

    // R5 R6 R11 receive word mode sweep
    for (int n = 1; n <= 64; n++) begin
      rx_push(pr(n - 1));
      snap(s);
      ceq("R6 R11 rx flags word mode", {24'd0, s},
          {24'd0, mk(0, 0, 1, n >= 61, n >= 32, n >= 4, 1, 0)});
    end
    rx_push(8'hF0);
    expect_ill("R7 push into full lane refused");
    for (int k = 0; k < 16; k++) begin
      rx_read(1'b1, 1'b0);
      ceq("R5 word read data", rx_rdata, {pr(4*k+3), pr(4*k+2), pr(4*k+1), pr(4*k)});
    end
    last = rx_rdata;
    rx_read(1'b1, 1'b0);
    ceq("R7 refused word read keeps rdata", rx_rdata, last);
    expect_ill("R7 word read when empty");

    // R5 R11 receive byte mode
    word_mode = 1'b0;
    for (int n = 1; n <= 16; n++) begin
      rx_push(8'(n*11));
      snap(s);
      ceq("R6 R11 rx flags byte mode", {24'd0, s},
          {24'd0, mk(0, 0, 1, n == 16, n >= 8, 0, 1, 0)});
    end
    rx_push(8'h01);
    expect_ill("R7 byte-mode push into full lane");
    rx_read(1'b1, 1'b0);
    ceq("R7 word read without word keeps rdata", rx_rdata, last);
    expect_ill("R7 word read without word");
    rx_read(1'b1, 1'b1);
    ceq("R8 double read keeps rdata", rx_rdata, last);
    expect_ill("R8 double rx read flagged");
    for (int n = 1; n <= 16; n++) begin
      rx_read(1'b0, 1'b1);
      ceq("R5 byte read data", rx_rdata, {24'd0, 8'(n*11)});
    end
    rx_read(1'b0, 1'b1);
    ceq("R7 byte read on empty keeps rdata", rx_rdata, {24'd0, 8'(16*11)});
    expect_ill("R7 byte read on empty");
    snap(s);
    ceq("R6 all empty", {24'd0, s}, {24'd0, mk(0, 0, 1, 0, 0, 0, 0, 0)});

    // R9 sticky clear
    int_clr = 8'h04;
    @(negedge clk);
    int_clr = 8'h00;
    ceq("R9 clear with live condition", {31'd0, int_status[2]}, 32'd1);
    tx_byte(8'h42);
    int_clr = 8'h04;
    @(negedge clk);
    int_clr = 8'h00;
    ceq("R9 clear after condition gone", {31'd0, int_status[2]}, 32'd0);
    rx_read(1'b0, 1'b1);
    ceq("R9 illegal set", {31'd0, int_status[7]}, 32'd1);
    @(negedge clk);
    ceq("R9 illegal sticks", {31'd0, int_status[7]}, 32'd1);
    int_clr = 8'h80;
    @(negedge clk);
    int_clr = 8'h00;
    ceq("R9 illegal cleared", {31'd0, int_status[7]}, 32'd0);
    tx_take("R2 single byte", 8'h42);

    // R10 interrupt masking
    int_en = 8'h80;
    rx_read(1'b0, 1'b1);
    ceq("R10 irq on enabled illegal", {31'd0, irq}, 32'd1);
    int_clr = 8'h80;
    @(negedge clk);
    int_clr = 8'h00;
    ceq("R10 irq drops after clear", {31'd0, irq}, 32'd0);
    int_en = 8'h04;
    @(negedge clk);
    ceq("R10 irq on tx empty", {31'd0, irq}, 32'd1);
    int_en = 8'h00;
    @(negedge clk);
    ceq("R10 irq masked", {31'd0, irq}, 32'd0);

    report();
  end
endmodule